// File: doc/BRIEF.md
# Single-Error-Correcting Feedthrough Memory Guard

This block sits in the data path between a processor and a protected memory. The processor side carries 16 data bits and 1 parity bit. The memory side carries the same 17 bits plus 6 check bits. The block has no state, so every path through it is combinational.

On a write, the processor word and its parity go straight to memory, and a fresh set of check bits is generated beside them. On a read, the stored word and check bits are folded into a 6-bit syndrome. The syndrome is used to repair a single flipped data bit when repair is enabled. Two active-low flags report a repairable error or an unrepairable one. An external fault input can force the unrepairable flag at any time.

Three select inputs and a direction input decide which side drives. The drive state is shown as output-enable signals rather than as tristate pads.

Top module: `edac_feedthrough`

## Requirements
- R1: On any cycle, `mem_out` equals `proc_in`: the 16 data bits and the parity bit (bit 16) are passed to memory unchanged.
- R2: `chk_out[r]` is the XOR of the data bits whose column contains row r, inverted for rows 2 and 3 (odd parity). Rows 0, 1, 4 and 5 use even parity. The columns for data bits 0 to 15 are {0,1,4} {0,1,5} {0,2,3} {0,2,4} {0,2,5} {0,3,4} {0,3,5} {0,4,5} {1,2,3} {1,2,4} {1,2,5} {1,3,4} {1,3,5} {1,4,5} {2,3,4} {2,3,5}, so an all-zero word yields `chk_out` = 6'b001100.
- R3: A stored word whose check bits match gives `proc_out[15:0]` equal to `mem_in[15:0]`, with both flags high.
- R4: With `fix_en` high, a single flipped stored data bit is corrected on `proc_out`, and `single_err_n` goes low.
- R5: A single flipped check bit leaves the data untouched and drives `single_err_n` low.
- R6: With `fix_en` low, `proc_out` equals `mem_in` exactly, even when an error is present.
- R7: Any two flipped bits among the 22 coded bits drive `multi_err_n` low and leave `single_err_n` high. The data is never altered in this case.
- R8: Unless `flag_en` is high and the device is selected, both flags stay high (except as R9 allows).
- R9: When `ext_fault_n` is low, `multi_err_n` is low, whatever the enables and selects.
- R10: The device is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. When selected with `dir_rd`=1, `proc_oe`=1 and `mem_oe`=0. When selected with `dir_rd`=0, `mem_oe`=1 and `proc_oe`=0. When unselected, both are 0.
- R11: `proc_out[16]` always equals `mem_in[16]`, including when a data bit is being corrected.
- R12: The flags are still evaluated from `mem_in`/`chk_in` during write cycles, so a fault on the memory side is reported while writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| proc_in | input | 17 | Processor-side word and parity (bit 16) |
| proc_out | output | 17 | Corrected word and parity toward the processor |
| proc_oe | output | 1 | Processor-side bus drive enable |
| mem_in | input | 17 | Stored word and parity from memory |
| mem_out | output | 17 | Word and parity toward memory |
| chk_in | input | 6 | Stored check bits from memory |
| chk_out | output | 6 | Generated check bits toward memory |
| mem_oe | output | 1 | Memory-side (data and check) bus drive enable |
| sel_a_n | input | 1 | Select, active low |
| sel_b_n | input | 1 | Select, active low |
| sel_c | input | 1 | Select, active high |
| dir_rd | input | 1 | 1 = read from memory, 0 = write to memory |
| fix_en | input | 1 | Enables single-bit repair on the read path |
| flag_en | input | 1 | Enables the two error flags |
| ext_fault_n | input | 1 | External fault, forces the unrepairable flag low |
| single_err_n | output | 1 | Repairable error flag, active low |
| multi_err_n | output | 1 | Unrepairable error flag, active low |

## Verification
The block holds no state, so a wrong internal value shows at the ports in the same cycle the memory word is presented.

- A wrong check-bit row or a wrong parity sense shows up as a wrong `chk_out` on a write. It also shows up as a spurious flag on a clean read.
- A wrong column in the repair decoder flips the wrong data bit, or none, on the first read with that bit in error.
- A wrong weight class swaps which flag falls.

Sweeping every single-bit and many double-bit corruptions across all 22 coded bits exposes each of these on the vector that touches it.

// File: rtl/edac_pkg.sv
// edac_pkg: widths, the parity-check matrix and shared types for the
// feedthrough EDAC. Assumes a 6-row code over 16 data bits; the matrix
// uses 16 of the 20 weight-3 columns so every row covers 8 data bits.
package edac_pkg;

    localparam int DATA_W = 16;
    localparam int CHK_W  = 6;
    localparam int PROC_W = DATA_W + 1;

    // Rows checked with odd parity (set bit = odd sense).
    localparam logic [CHK_W-1:0] ODD_ROWS = 6'b001100;

    // Weight-3 columns left out so each row keeps exactly 8 ones.
    localparam logic [CHK_W-1:0] SKIP_A = 6'b000111;
    localparam logic [CHK_W-1:0] SKIP_B = 6'b001011;
    localparam logic [CHK_W-1:0] SKIP_C = 6'b110100;
    localparam logic [CHK_W-1:0] SKIP_D = 6'b111000;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_SINGLE = 2'd1,
        ERR_MULTI  = 2'd2
    } err_class_t;

    // Enumerates weight-3 columns in ascending row order, dropping four.
    function automatic logic [DATA_W*CHK_W-1:0] build_cols();
        logic [DATA_W*CHK_W-1:0] cols;
        logic [CHK_W-1:0]        c;
        int                      n;
        cols = '0;
        n    = 0;
        for (int i = 0; i < CHK_W; i++) begin
            for (int j = i + 1; j < CHK_W; j++) begin
                for (int k = j + 1; k < CHK_W; k++) begin
                    c    = '0;
                    c[i] = 1'b1;
                    c[j] = 1'b1;
                    c[k] = 1'b1;
                    if (c != SKIP_A && c != SKIP_B && c != SKIP_C &&
                        c != SKIP_D && n < DATA_W) begin
                        cols[n*CHK_W +: CHK_W] = c;
                        n++;
                    end
                end
            end
        end
        return cols;
    endfunction

    localparam logic [DATA_W*CHK_W-1:0] H_COLS = build_cols();

    // Data bits feeding check row r.
    function automatic logic [DATA_W-1:0] row_mask(input int r);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < DATA_W; b++) begin
            m[b] = H_COLS[b*CHK_W + r];
        end
        return m;
    endfunction

endpackage

// File: rtl/edac_chkgen.sv
// edac_chkgen: one parity tree per check row. Used both to generate
// check bits (chk_mix tied to zero) and to form the syndrome (chk_mix =
// stored check bits). Assumes purely combinational use.
module edac_chkgen
    import edac_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [CHK_W-1:0]  chk_mix,
    output logic [CHK_W-1:0]  parity
);

    for (genvar r = 0; r < CHK_W; r++) begin : g_row
        localparam logic [DATA_W-1:0] MASK = row_mask(r);
        // Parity of the covered data bits, folded with check bit and sense.
        always_comb begin
            parity[r] = (^(data & MASK)) ^ chk_mix[r] ^ ODD_ROWS[r];
        end
    end

endmodule

// File: rtl/edac_corrector.sv
// edac_corrector: matches the syndrome against each data column and
// inverts the single matching bit when repair is enabled. A syndrome
// matching no column leaves the data as read.
module edac_corrector
    import edac_pkg::*;
(
    input  logic [CHK_W-1:0]  syndrome,
    input  logic [DATA_W-1:0] raw,
    input  logic              fix_en,
    output logic [DATA_W-1:0] fixed
);

    logic [DATA_W-1:0] hit;

    for (genvar b = 0; b < DATA_W; b++) begin : g_col
        localparam logic [CHK_W-1:0] COL = H_COLS[b*CHK_W +: CHK_W];
        // Flag this bit when the syndrome points at its column.
        always_comb begin
            hit[b] = (syndrome == COL);
        end
    end

    // Apply the flip only when repair is enabled.
    always_comb begin
        fixed = raw ^ (hit & {DATA_W{fix_en}});
    end

endmodule

// File: rtl/edac_flagger.sv
// edac_flagger: classifies the syndrome by its number of set bits and
// drives the two active-low flags. The external fault path bypasses all
// enables.
module edac_flagger
    import edac_pkg::*;
(
    input  logic [CHK_W-1:0] syndrome,
    input  logic             flags_on,
    input  logic             ext_fault_n,
    output logic             single_err_n,
    output logic             multi_err_n
);

    err_class_t  cls;
    logic [2:0]  weight;

    // Weight-based classification: 1 or 3 repairable, 2 or 4+ not.
    always_comb begin
        weight = 3'($countones(syndrome));
        case (weight)
            3'd0:       cls = ERR_NONE;
            3'd1, 3'd3: cls = ERR_SINGLE;
            default:    cls = ERR_MULTI;
        endcase
    end

    // Gate with enables, then merge the external fault.
    always_comb begin
        single_err_n = !(flags_on && cls == ERR_SINGLE);
        multi_err_n  = !((flags_on && cls == ERR_MULTI) || !ext_fault_n);
    end

endmodule

// File: rtl/edac_busctl.sv
// edac_busctl: decodes the three selects and the direction into the
// select state and the two bus drive enables.
module edac_busctl (
    input  logic sel_a_n,
    input  logic sel_b_n,
    input  logic sel_c,
    input  logic dir_rd,
    output logic selected,
    output logic proc_oe,
    output logic mem_oe
);

    // Selection and direction-dependent drive enables.
    always_comb begin
        selected = !sel_a_n && !sel_b_n && sel_c;
        proc_oe  = selected && dir_rd;
        mem_oe   = selected && !dir_rd;
    end

endmodule

// File: rtl/edac_feedthrough.sv
// edac_feedthrough: top of the feedthrough EDAC. Write path forwards the
// processor word and generates check bits; read path forms the syndrome
// from the memory side, repairs one data bit and raises flags. Bus
// direction is reported as output enables. No clock, no state.
module edac_feedthrough
    import edac_pkg::*;
(
    input  logic [PROC_W-1:0] proc_in,
    output logic [PROC_W-1:0] proc_out,
    output logic              proc_oe,
    input  logic [PROC_W-1:0] mem_in,
    output logic [PROC_W-1:0] mem_out,
    input  logic [CHK_W-1:0]  chk_in,
    output logic [CHK_W-1:0]  chk_out,
    output logic              mem_oe,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              sel_c,
    input  logic              dir_rd,
    input  logic              fix_en,
    input  logic              flag_en,
    input  logic              ext_fault_n,
    output logic              single_err_n,
    output logic              multi_err_n
);

    localparam int PAR_BIT = PROC_W - 1;

    logic              selected;
    logic [CHK_W-1:0]  syndrome;
    logic [DATA_W-1:0] fixed_data;

    edac_busctl i_busctl (
        .sel_a_n  (sel_a_n),
        .sel_b_n  (sel_b_n),
        .sel_c    (sel_c),
        .dir_rd   (dir_rd),
        .selected (selected),
        .proc_oe  (proc_oe),
        .mem_oe   (mem_oe)
    );

    edac_chkgen i_encode (
        .data    (proc_in[DATA_W-1:0]),
        .chk_mix ('0),
        .parity  (chk_out)
    );

    edac_chkgen i_syndrome (
        .data    (mem_in[DATA_W-1:0]),
        .chk_mix (chk_in),
        .parity  (syndrome)
    );

    edac_corrector i_fix (
        .syndrome (syndrome),
        .raw      (mem_in[DATA_W-1:0]),
        .fix_en   (fix_en),
        .fixed    (fixed_data)
    );

    edac_flagger i_flags (
        .syndrome     (syndrome),
        .flags_on     (selected && flag_en),
        .ext_fault_n  (ext_fault_n),
        .single_err_n (single_err_n),
        .multi_err_n  (multi_err_n)
    );

    // Data and parity forwarding in both directions.
    always_comb begin
        mem_out  = proc_in;
        proc_out = {mem_in[PAR_BIT], fixed_data};
    end

endmodule

// File: rtl/edac_feedthrough_chk.sv
// edac_feedthrough_chk: port-level rules for the feedthrough EDAC,
// evaluated whenever the combinational outputs settle.
module edac_feedthrough_chk
    import edac_pkg::*;
(
    input logic [PROC_W-1:0] proc_in,
    input logic [PROC_W-1:0] proc_out,
    input logic              proc_oe,
    input logic [PROC_W-1:0] mem_in,
    input logic [PROC_W-1:0] mem_out,
    input logic              mem_oe,
    input logic              sel_a_n,
    input logic              sel_b_n,
    input logic              sel_c,
    input logic              fix_en,
    input logic              flag_en,
    input logic              ext_fault_n,
    input logic              single_err_n,
    input logic              multi_err_n
);

    logic sel_chk;

    // Settled-value checks on the port relations.
    always_comb begin
        sel_chk = !sel_a_n && !sel_b_n && sel_c;
        a_r1_write_forward: assert (mem_out == proc_in)
            else $error("R1 memory-side word differs from processor word");
        a_r6_raw_pass: assert (fix_en || proc_out == mem_in)
            else $error("R6 data altered with repair disabled");
        a_r7_flags_exclusive: assert (!ext_fault_n || single_err_n || multi_err_n)
            else $error("R7 both flags low without external fault");
        a_r8_flags_gated: assert (!ext_fault_n || (sel_chk && flag_en) ||
                                  (single_err_n && multi_err_n))
            else $error("R8 flag active while flags disabled");
        a_r9_ext_fault: assert (ext_fault_n || !multi_err_n)
            else $error("R9 external fault not forwarded");
        a_r10_idle_quiet: assert (sel_chk || (!proc_oe && !mem_oe))
            else $error("R10 bus driven while unselected");
        a_r10_one_driver: assert (!(proc_oe && mem_oe))
            else $error("R10 both buses driven");
        a_r11_parity_pass: assert (proc_out[PROC_W-1] == mem_in[PROC_W-1])
            else $error("R11 parity bit changed on read path");
    end

endmodule

bind edac_feedthrough edac_feedthrough_chk i_chk (.*);

// File: tb/test_edac_feedthrough.sv
// Bench for edac_feedthrough: table-driven reads, random single/double
// corruptions, then directed write, bus and flag-enable cases.
module test_edac_feedthrough;

    logic        clk = 1'b0;
    logic [16:0] proc_in, proc_out, mem_in, mem_out;
    logic [5:0]  chk_in, chk_out;
    logic        proc_oe, mem_oe;
    logic        sel_a_n, sel_b_n, sel_c, dir_rd;
    logic        fix_en, flag_en, ext_fault_n;
    logic        single_err_n, multi_err_n;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    edac_feedthrough i_edac_feedthrough (.*);

    // Column of each data bit (row set), from R2.
    localparam logic [5:0] COLS [16] = '{
        6'b010011, 6'b100011, 6'b001101, 6'b010101,
        6'b100101, 6'b011001, 6'b101001, 6'b110001,
        6'b001110, 6'b010110, 6'b100110, 6'b011010,
        6'b101010, 6'b110010, 6'b011100, 6'b101100 };
    localparam logic [5:0] ODD = 6'b001100;

    // {data, flip over 22 coded bits (21:16 check), fix_en, flag_en}
    localparam logic [39:0] VEC [12] = '{
        {16'h0000, 22'h000000, 1'b1, 1'b1},
        {16'hA5C3, 22'h000000, 1'b1, 1'b1},
        {16'hA5C3, 22'h000001, 1'b1, 1'b1},
        {16'hA5C3, 22'h008000, 1'b1, 1'b1},
        {16'h1234, 22'h000080, 1'b0, 1'b1},
        {16'h1234, 22'h010000, 1'b1, 1'b1},
        {16'hFFFF, 22'h200000, 1'b1, 1'b1},
        {16'hFFFF, 22'h000208, 1'b1, 1'b1},
        {16'h0F0F, 22'h040004, 1'b1, 1'b1},
        {16'h0F0F, 22'h030000, 1'b1, 1'b1},
        {16'h8001, 22'h000010, 1'b1, 1'b0},
        {16'h8001, 22'h000030, 1'b1, 1'b0} };

    function automatic logic [5:0] enc(input logic [15:0] d);
        logic [5:0] p;
        p = ODD;
        for (int b = 0; b < 16; b++) begin
            p = p ^ (COLS[b] & {6{d[b]}});
        end
        return p;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_bus(input logic a_n, input logic b_n, input logic c, input logic rd);
        sel_a_n = a_n; sel_b_n = b_n; sel_c = c; dir_rd = rd;
    endtask

    // Present a corrupted stored word on a read and check all outputs.
    task automatic do_read(input logic [15:0] d, input logic par,
                           input logic [21:0] flip, input logic fx, input logic fl);
        logic [15:0] exp_d;
        int          w;
        @(posedge clk); #1;
        set_bus(1'b0, 1'b0, 1'b1, 1'b1);
        fix_en = fx; flag_en = fl; ext_fault_n = 1'b1;
        mem_in = {par, d ^ flip[15:0]};
        chk_in = enc(d) ^ flip[21:16];
        w = $countones(flip);
        exp_d = d ^ flip[15:0];
        if (fx && w == 1) exp_d = d;                // R4 repair, R5 data intact
        @(negedge clk);
        chk("R3/R4/R5/R6/R7 data", {16'h0, proc_out[15:0]}, {16'h0, exp_d});
        chk("R11 parity", {31'h0, proc_out[16]}, {31'h0, par});
        chk("R4/R5 single flag", {31'h0, single_err_n}, {31'h0, !(fl && w == 1)});
        chk("R7/R8 multi flag", {31'h0, multi_err_n}, {31'h0, !(fl && w == 2)});
        chk("R10 read drive", {30'h0, proc_oe, mem_oe}, {30'h0, 2'b10});
    endtask

    initial begin
        proc_in = '0; mem_in = '0; chk_in = '0;
        set_bus(1'b1, 1'b1, 1'b0, 1'b1);
        fix_en = 1'b1; flag_en = 1'b1; ext_fault_n = 1'b1;
        @(negedge clk);
        // Idle state: unselected, nothing driven, flags inactive (R10, R8).
        chk("R10 idle drive", {30'h0, proc_oe, mem_oe}, 32'h0);
        chk("R8 idle flags", {30'h0, single_err_n, multi_err_n}, 32'h3);

        for (int i = 0; i < 12; i++) begin
            do_read(VEC[i][39:24], 1'(i % 2), VEC[i][23:2], VEC[i][1], VEC[i][0]);
        end

        // Random single and double corruptions across all 22 coded bits.
        for (int k = 0; k < 400; k++) begin
            logic [21:0] fl;
            int          nf, p1, p2;
            nf = $urandom_range(0, 2);
            p1 = $urandom_range(0, 21);
            p2 = (p1 + 1 + $urandom_range(0, 20)) % 22;
            fl = '0;
            if (nf >= 1) fl[p1] = 1'b1;
            if (nf == 2) fl[p2] = 1'b1;
            do_read(16'($urandom), 1'($urandom), fl, 1'b1, 1'b1);
        end

        // R2: all-zero word check bits, then an encode sweep on writes.
        @(posedge clk); #1;
        set_bus(1'b0, 1'b0, 1'b1, 1'b0);
        proc_in = 17'h10000;
        mem_in = 17'h00000; chk_in = 6'b001100;
        @(negedge clk);
        chk("R2 zero word check bits", {26'h0, chk_out}, 32'h0000000C);
        chk("R1 write forward", {15'h0, mem_out}, {15'h0, proc_in});
        chk("R10 write drive", {30'h0, proc_oe, mem_oe}, {30'h0, 2'b01});
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); #1;
            proc_in = 17'($urandom);
            mem_in = proc_in; chk_in = enc(proc_in[15:0]);
            @(negedge clk);
            chk("R2 check bits", {26'h0, chk_out}, {26'h0, enc(proc_in[15:0])});
            chk("R1 write forward", {15'h0, mem_out}, {15'h0, proc_in});
            chk("R12 clean write flags", {30'h0, single_err_n, multi_err_n}, 32'h3);
        end

        // R12: memory-side fault seen during a write.
        @(posedge clk); #1;
        chk_in = enc(mem_in[15:0]) ^ 6'b000100;
        @(negedge clk);
        chk("R12 write single flag", {31'h0, single_err_n}, 32'h0);
        @(posedge clk); #1;
        mem_in[3] = ~mem_in[3]; mem_in[9] = ~mem_in[9];
        chk_in = enc(proc_in[15:0]);
        @(negedge clk);
        chk("R12 write multi flag", {31'h0, multi_err_n}, 32'h0);

        // R8: error present but unselected -> flags inactive, no drive.
        @(posedge clk); #1;
        set_bus(1'b0, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        chk("R8 unselected flags", {30'h0, single_err_n, multi_err_n}, 32'h3);
        chk("R10 unselected drive", {30'h0, proc_oe, mem_oe}, 32'h0);
        @(posedge clk); #1;
        set_bus(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R10 sel_c low drive", {30'h0, proc_oe, mem_oe}, 32'h0);

        // R9: external fault while unselected and flags disabled.
        @(posedge clk); #1;
        flag_en = 1'b0; ext_fault_n = 1'b0;
        @(negedge clk);
        chk("R9 external fault", {30'h0, single_err_n, multi_err_n}, 32'h2);
        @(posedge clk); #1;
        ext_fault_n = 1'b1;
        @(negedge clk);
        chk("R9 external fault released", {31'h0, multi_err_n}, 32'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule